// File: doc/BRIEF.md
# Access-Triggered Slowdown Delay Controller

This block sits beside a CPU accelerator and decides, cycle by cycle, whether the accelerator has to drop back to motherboard speed. It watches the CPU bus address, an access strobe with its write flag, and the interrupt line. Certain events each open their own timed slow window. These events are a paddle or joystick access, a speaker toggle, a read of the video counters, an interrupt, and an I/O access to an expansion slot. A second access to the same source while its window is open restarts that window at full length.

The windows are counted in ticks of a 1 MHz enable input. There is a short window of about 5 ms for the paddle, speaker, video counter and interrupt sources, and a long window of about 53 ms for each slot. Each source has its own enable. The merged `delay_active` flag is high while any window is open. The `slow` output adds one more condition: when following is enabled, it is also high whenever the system asks for 1 MHz operation. A write anywhere in the block's control range closes every open window at once. Software uses this to end a slowdown early.

Top module: `slowdown_ctrl`

## Requirements
- R1: With `en_paddle` set, a bus access of either direction to 16'hC070 or 16'hC020 opens the short window. With it clear, such an access has no effect.
- R2: With `en_speaker` set, a bus access of either direction to 16'hC030 opens the short window. With it clear, such an access has no effect.
- R3: With `en_vcount` set, a read (bus_we=0) of 16'hC02E or 16'hC07E opens the short window. Writes to those addresses never open it.
- R4: With `en_irq` set, a rising edge of `irq` opens the short window. Holding `irq` high does not reopen it.
- R5: An access of either direction to 16'hC080+16*s through 16'hC08F+16*s, for slot s in 1..7, opens that slot's long window when `en_slot[s-1]` is set. The range 16'hC080..16'hC08F belongs to no slot.
- R6: `delay_active` rises in the cycle after the triggering access. It stays high for exactly N cycles in which `tick_1us` is high (N = SHORT_TICKS or SLOT_TICKS), then falls. While `tick_1us` is low, an open window does not shrink.
- R7: A new trigger for a source whose window is open reloads that window to its full length.
- R8: A write (bus_we=1) to any address from 16'hC058 to 16'hC05F closes every open window by the next cycle. That write does not open any window. A read in that range changes nothing.
- R9: With `en_follow` set, `slow` is high in the cycle after `sys_slow` is high. With `en_follow` clear, `sys_slow` has no effect on `slow`.
- R10: `slow` is high whenever `delay_active` is high. `delay_active` reflects the timed windows only, never the follow condition.
- R11: After reset, `slow` and `delay_active` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A CPU bus access is present this cycle |
| bus_we | input | 1 | The access is a write |
| bus_addr | input | 16 | CPU address of the access |
| irq | input | 1 | Interrupt request level |
| sys_slow | input | 1 | System requests 1 MHz operation |
| en_follow | input | 1 | Follow the system speed request |
| en_paddle | input | 1 | Enable the paddle source |
| en_speaker | input | 1 | Enable the speaker source |
| en_vcount | input | 1 | Enable the video counter source |
| en_irq | input | 1 | Enable the interrupt source |
| en_slot | input | 7 | Per-slot enables; bit s-1 is slot s |
| tick_1us | input | 1 | One-cycle 1 MHz timebase enable |
| slow | output | 1 | Accelerator must run at motherboard speed |
| delay_active | output | 1 | At least one timed window is open |

## Verification
A decode fault, such as a wrong address, a wrong direction or an enable that is ignored, shows up at `delay_active` one cycle after the offending access. That is the cycle in which the output should have risen, or should have stayed low. A counter that loads the wrong length or wrongly decrements shows up only at the end of the window. For that reason the window edges are checked on the exact cycles N-1 and N after the trigger, and again after a restart. A cancel that misses a counter leaves `delay_active` high on the cycle after the control write, which is the cycle where it is checked.

// File: rtl/slowdown_pkg.sv
package slowdown_pkg;

  // source indices in the trigger / window vectors
  localparam int SRC_PAD   = 0;
  localparam int SRC_SPK   = 1;
  localparam int SRC_VC    = 2;
  localparam int SRC_IRQ   = 3;
  localparam int SRC_SLOT1 = 4;
  localparam int NUM_SLOTS = 7;
  localparam int NSRC      = SRC_SLOT1 + NUM_SLOTS;

  function automatic logic in_io_page(input logic [15:0] a);
    return a[15:8] == 8'hC0;
  endfunction

  function automatic logic hit_paddle(input logic [15:0] a);
    return (a == 16'hC070) || (a == 16'hC020);
  endfunction

  function automatic logic hit_speaker(input logic [15:0] a);
    return a == 16'hC030;
  endfunction

  function automatic logic hit_vcount(input logic [15:0] a);
    return (a == 16'hC02E) || (a == 16'hC07E);
  endfunction

  // eight control locations C058..C05F
  function automatic logic hit_ctrl(input logic [15:0] a);
    return a[15:3] == 13'h180B;
  endfunction

  // slot number 1..7 for C090..C0FF, 0 for anything else
  function automatic logic [2:0] slot_of(input logic [15:0] a);
    return (in_io_page(a) && a[7]) ? a[6:4] : 3'd0;
  endfunction

  function automatic int unsigned window_len(input int idx,
                                             input int unsigned short_t,
                                             input int unsigned slot_t);
    return (idx >= SRC_SLOT1) ? slot_t : short_t;
  endfunction

  function automatic int unsigned max_u(input int unsigned a,
                                        input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/slowdown_irq_edge.sv
module slowdown_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  output logic irq_rise
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq;
  end

  assign irq_rise = irq & ~irq_q;
endmodule

// File: rtl/slowdown_decode.sv
module slowdown_decode
  import slowdown_pkg::*;
(
  input  logic            bus_valid,
  input  logic            bus_we,
  input  logic [15:0]     bus_addr,
  input  logic            irq_rise,
  input  logic [NSRC-1:0] en_vec,
  output logic [NSRC-1:0] trig_vec,
  output logic            cancel_evt
);
  assign trig_vec[SRC_PAD] = bus_valid && en_vec[SRC_PAD] && hit_paddle(bus_addr);
  assign trig_vec[SRC_SPK] = bus_valid && en_vec[SRC_SPK] && hit_speaker(bus_addr);
  assign trig_vec[SRC_VC]  = bus_valid && !bus_we && en_vec[SRC_VC] &&
                             hit_vcount(bus_addr);
  assign trig_vec[SRC_IRQ] = irq_rise && en_vec[SRC_IRQ];

  for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
    assign trig_vec[SRC_SLOT1+s-1] = bus_valid && en_vec[SRC_SLOT1+s-1] &&
                                     (slot_of(bus_addr) == 3'(s));
  end

  assign cancel_evt = bus_valid && bus_we && hit_ctrl(bus_addr);
endmodule

// File: rtl/slowdown_window.sv
module slowdown_window #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LEN   = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  input  logic tick,
  output logic active
);
  logic [CNT_W-1:0] cnt;

  // a start beats a cancel arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (start)               cnt <= CNT_W'(LEN);
    else if (cancel)              cnt <= '0;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/slowdown_ctrl.sv
module slowdown_ctrl
  import slowdown_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 5000,
  parameter int unsigned SLOT_TICKS  = 53000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic        irq,
  input  logic        sys_slow,
  input  logic        en_follow,
  input  logic        en_paddle,
  input  logic        en_speaker,
  input  logic        en_vcount,
  input  logic        en_irq,
  input  logic [6:0]  en_slot,
  input  logic        tick_1us,
  output logic        slow,
  output logic        delay_active
);
  localparam int unsigned CNT_W = $clog2(max_u(SHORT_TICKS, SLOT_TICKS) + 1);

  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] trig_vec;
  logic [NSRC-1:0] win_active;
  logic            irq_rise;
  logic            cancel_evt;
  logic            follow_q;

  assign en_vec = {en_slot, en_irq, en_vcount, en_speaker, en_paddle};

  slowdown_irq_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .irq_rise (irq_rise)
  );

  slowdown_decode u_dec (
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .irq_rise   (irq_rise),
    .en_vec     (en_vec),
    .trig_vec   (trig_vec),
    .cancel_evt (cancel_evt)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_win
    slowdown_window #(
      .CNT_W (CNT_W),
      .LEN   (window_len(i, SHORT_TICKS, SLOT_TICKS))
    ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (trig_vec[i]),
      .cancel (cancel_evt),
      .tick   (tick_1us),
      .active (win_active[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) follow_q <= 1'b0;
    else        follow_q <= en_follow & sys_slow;
  end

  assign delay_active = |win_active;
  assign slow         = delay_active | follow_q;
endmodule

// File: rtl/slowdown_ctrl_chk.sv
module slowdown_ctrl_chk #(
  parameter int NSRC = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic            tick_1us,
  input logic            en_follow,
  input logic            sys_slow,
  input logic            slow,
  input logic            delay_active,
  input logic [NSRC-1:0] trig_vec,
  input logic            cancel_evt
);
  // R6
  trig_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_vec != '0) |=> delay_active);

  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!delay_active && trig_vec == '0) |=> !delay_active);

  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_active && !tick_1us && !cancel_evt) |=> delay_active);

  // R8
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_evt && trig_vec == '0) |=> !delay_active);

  // R3
  vcount_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> !trig_vec[2]);

  // R9
  follow_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_follow && sys_slow) |=> slow);

  // R10
  delay_implies_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_active |-> slow);
endmodule

bind slowdown_ctrl slowdown_ctrl_chk #(.NSRC(slowdown_pkg::NSRC)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_we       (bus_we),
  .tick_1us     (tick_1us),
  .en_follow    (en_follow),
  .sys_slow     (sys_slow),
  .slow         (slow),
  .delay_active (delay_active),
  .trig_vec     (trig_vec),
  .cancel_evt   (cancel_evt)
);

// File: tb/slowdown_ctrl_tb_top.sv
module slowdown_ctrl_tb_top;
  localparam int SHORT_N = 8;
  localparam int SLOT_N  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic irq = 1'b0, sys_slow = 1'b0, en_follow = 1'b0;
  logic [10:0] en = 11'h000;
  logic tick_1us = 1'b1;
  logic slow, delay_active;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  slowdown_ctrl #(.SHORT_TICKS(SHORT_N), .SLOT_TICKS(SLOT_N)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .bus_valid (bus_valid), .bus_we (bus_we), .bus_addr (bus_addr),
    .irq (irq), .sys_slow (sys_slow), .en_follow (en_follow),
    .en_paddle (en[0]), .en_speaker (en[1]), .en_vcount (en[2]),
    .en_irq (en[3]), .en_slot (en[10:4]), .tick_1us (tick_1us),
    .slow (slow), .delay_active (delay_active)
  );

  // en bits: 0 paddle, 1 speaker, 2 vcount, 3 irq, 4..10 slot1..7
  typedef struct packed {
    logic [15:0] a;
    logic        we;
    logic [10:0] en;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{16'hC070, 1'b0, 11'h001, 1'b1},  // R1
    '{16'hC070, 1'b0, 11'h7FE, 1'b0},  // R1 disabled
    '{16'hC020, 1'b1, 11'h001, 1'b1},  // R1 write
    '{16'hC030, 1'b0, 11'h002, 1'b1},  // R2
    '{16'hC030, 1'b1, 11'h7FD, 1'b0},  // R2 disabled
    '{16'hC02E, 1'b0, 11'h004, 1'b1},  // R3
    '{16'hC07E, 1'b1, 11'h7FF, 1'b0},  // R3 write ignored
    '{16'hC07E, 1'b0, 11'h004, 1'b1},  // R3
    '{16'hC0E5, 1'b0, 11'h200, 1'b1},  // R5 slot 6
    '{16'hC0E5, 1'b0, 11'h5F0, 1'b0},  // R5 slot 6 disabled
    '{16'hC09F, 1'b1, 11'h010, 1'b1},  // R5 slot 1
    '{16'hC0F0, 1'b0, 11'h400, 1'b1},  // R5 slot 7
    '{16'hC085, 1'b0, 11'h7FF, 1'b0},  // R5 no slot 0
    '{16'hC000, 1'b0, 11'h7FF, 1'b0},  // R1 unrelated address
    '{16'hC071, 1'b1, 11'h7FF, 1'b0},  // R1 neighbour address
    '{16'hC05C, 1'b1, 11'h7FF, 1'b0}   // R8 control write no trigger
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [15:0] a, input logic we);
    bus_addr = a; bus_we = we; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R11 reset state
    check(delay_active, 1'b0, "R11 delay_active in reset");
    check(slow, 1'b0, "R11 slow in reset");
    rst_n = 1'b1;
    cyc(2);
    check(delay_active, 1'b0, "R11 delay_active after reset");

    for (int i = 0; i < 16; i++) begin
      en = VEC[i].en;
      access(VEC[i].a, VEC[i].we);
      check(delay_active, VEC[i].exp, $sformatf("R1-5 vector %0d", i));
      if (VEC[i].exp) check(slow, 1'b1, "R10 slow follows window");
      access(16'hC058, 1'b1);
      en = 11'h000;
      cyc(1);
    end

    // R6 short window length
    en = 11'h001;
    access(16'hC070, 1'b0);
    cyc(SHORT_N - 1);
    check(delay_active, 1'b1, "R6 short window last cycle");
    cyc(1);
    check(delay_active, 1'b0, "R6 short window ended");

    // R6 slot window length
    en = 11'h040;  // slot 3
    access(16'hC0B2, 1'b0);
    cyc(SLOT_N - 1);
    check(delay_active, 1'b1, "R6 slot window last cycle");
    cyc(1);
    check(delay_active, 1'b0, "R6 slot window ended");

    // R7 restart
    en = 11'h002;
    access(16'hC030, 1'b0);
    cyc(4);
    access(16'hC030, 1'b1);
    cyc(SHORT_N - 1);
    check(delay_active, 1'b1, "R7 restarted window still open");
    cyc(1);
    check(delay_active, 1'b0, "R7 restarted window ended");

    // R8 cancel, and read in range ignored
    en = 11'h7FF;
    access(16'hC0E0, 1'b0);
    access(16'hC05A, 1'b0);
    check(delay_active, 1'b1, "R8 control read ignored");
    access(16'hC05F, 1'b1);
    check(delay_active, 1'b0, "R8 control write cancels");
    en = 11'h000;

    // R6 no tick freezes the window
    en = 11'h001;
    tick_1us = 1'b0;
    access(16'hC020, 1'b0);
    cyc(3 * SHORT_N);
    check(delay_active, 1'b1, "R6 no tick keeps window");
    tick_1us = 1'b1;
    cyc(SHORT_N);
    check(delay_active, 1'b0, "R6 ticks resume and expire");

    // R4 interrupt edge
    en = 11'h008;
    irq = 1'b1;
    cyc(1);
    check(delay_active, 1'b1, "R4 irq edge opens window");
    cyc(SHORT_N + 4);
    check(delay_active, 1'b0, "R4 held irq no retrigger");
    irq = 1'b0;
    en = 11'h000;
    cyc(1);
    irq = 1'b1;
    cyc(1);
    check(delay_active, 1'b0, "R4 irq disabled");
    irq = 1'b0;

    // R9 follow
    sys_slow = 1'b1;
    cyc(2);
    check(slow, 1'b0, "R9 follow disabled ignores sys_slow");
    en_follow = 1'b1;
    cyc(1);
    check(slow, 1'b1, "R9 follow sets slow");
    check(delay_active, 1'b0, "R10 follow not in delay_active");
    sys_slow = 1'b0;
    cyc(1);
    check(slow, 1'b0, "R9 follow released");
    en_follow = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule